// File: doc/BRIEF.md
# TLB Associative Search Unit

This block holds a small, fully associative table of address translations and answers search requests against it. A search forms an effective address from two operand values, where a zero operand selector forces the base to zero. It then compares the page-number part of that address, plus a search context, against every entry at the same time. The context is made of guest state, partition ID, address space, process ID, an indirect flag and the executing thread. Each entry applies its own page-size mask to the comparison. Zero partition or process IDs stored in an entry act as wildcards.

One cycle after a search strobe, the block reports whether an entry matched, the index of the lowest matching entry and its real page number. It also updates a set of management result fields: array select, entry select, hardware-entry-select, write qualifier and result-valid. A search can ask for condition flags. A caller in guest state, or a search issued while the table is switched off, raises an exception instead of searching. Entries are loaded one per cycle through a plain write port.

Top module: `tlb_search_unit`

## Requirements
- R1: The effective address is (ra_sel == 0 ? 0 : ra_val) + rb_val, computed modulo 2^64. The page number compared is bits 63:12 of that address.
- R2: An entry with size field s >= 1 ignores the low 2*(s-1) bits of the page number in the comparison. A size of 0 compares every bit, the same as size 1.
- R3: An entry whose stored partition ID is 0 matches any search partition ID. An entry whose stored process ID is 0 matches any search process ID. A nonzero stored ID must equal the search ID.
- R4: An entry matches only if all of these hold: it is valid; its guest bit equals srch_gs; its address-space bit equals srch_as; its indirect bit equals srch_ind; and its thread-enable bit at position thread_id is set.
- R5: When several entries match, the lowest index is reported.
- R6: A search that proceeds updates its outputs on the clock edge that samples srch_req, and done is 1 for that one cycle. On a hit, these outputs take new values: hit=1, hit_idx is the index, hit_rpn is the entry's real page number, mas_atsel=0, mas_esel is the index, mas_hes=cfg_hes, mas_wq=2'b01 and mas_v=1.
- R7: On a miss, hit=0 and mas_v=0. hit_idx, hit_rpn, mas_esel, mas_hes, mas_wq and mas_atsel keep their previous values.
- R8: A search that proceeds with srch_rc=1 pulses cr_we together with done. It sets cr_flags to {LT=bit3:0, GT=bit2:0, EQ=bit1:hit, SO=bit0:0}. With srch_rc=0, cr_we stays 0 and cr_flags is held.
- R9: srch_req with cur_gs=1 pulses exc_priv for one cycle, with no search: done stays 0 and every result output is held. This takes priority over R10.
- R10: srch_req with cur_gs=0 and tlb_off=1 pulses exc_ill for one cycle, with no search: done stays 0 and every result output is held.
- R11: A write loads one entry per cycle at wr_idx. A search strobed on any later cycle sees the new contents.
- R12: Once reset has been released, every entry is invalid and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 4 | Entry index to load |
| wr_valid | input | 1 | Entry valid bit |
| wr_gs | input | 1 | Entry guest-state bit |
| wr_lpid | input | 8 | Entry partition ID (0 = any) |
| wr_as | input | 1 | Entry address-space bit |
| wr_pid | input | 14 | Entry process ID (0 = any) |
| wr_ind | input | 1 | Entry indirect bit |
| wr_thd | input | 4 | Entry per-thread enable bits |
| wr_size | input | 4 | Entry page-size code |
| wr_epn | input | 52 | Entry page number |
| wr_rpn | input | 30 | Entry real page number |
| srch_req | input | 1 | Search strobe |
| srch_rc | input | 1 | Request condition flags |
| ra_sel | input | 5 | Base operand selector, 0 forces a zero base |
| ra_val | input | 64 | Base operand value |
| rb_val | input | 64 | Index operand value |
| srch_gs | input | 1 | Search guest state |
| srch_lpid | input | 8 | Search partition ID |
| srch_as | input | 1 | Search address space |
| srch_pid | input | 14 | Search process ID |
| srch_ind | input | 1 | Search indirect value |
| thread_id | input | 2 | Executing thread |
| cur_gs | input | 1 | Caller runs in guest state |
| tlb_off | input | 1 | Table disabled mode |
| cfg_hes | input | 1 | Configuration value copied to mas_hes |
| done | output | 1 | Search performed last edge |
| hit | output | 1 | Last search hit |
| hit_idx | output | 4 | Index of last hit |
| hit_rpn | output | 30 | Real page number of last hit |
| mas_atsel | output | 1 | Result array select |
| mas_esel | output | 4 | Result entry select |
| mas_hes | output | 1 | Result hardware-entry-select |
| mas_wq | output | 2 | Result write qualifier |
| mas_v | output | 1 | Result valid |
| cr_we | output | 1 | Condition flags written |
| cr_flags | output | 4 | Condition flags LT,GT,EQ,SO |
| exc_priv | output | 1 | Privilege exception pulse |
| exc_ill | output | 1 | Illegal operation pulse |

## Verification
The hardest case to reach from the ports is two entries matching at once through different mechanisms. In the bench, a large-page entry at a lower index covers the exact page of a small-page entry at a higher index, and both use wildcard IDs, so only the priority rule can choose between them. A second hard case is showing that a miss or a refused search leaves the stored fields untouched. To reach it, the bench first makes a hit with known values, then issues a miss or an exception and reads the same outputs again.

// File: rtl/tlb_search_pkg.sv
package tlb_search_pkg;
  parameter int EA_W     = 64;
  parameter int PG_SHIFT = 12;
  parameter int EPN_W    = EA_W - PG_SHIFT;
  parameter int LPID_W   = 8;
  parameter int PID_W    = 14;
  parameter int NTHR     = 4;
  parameter int TID_W    = $clog2(NTHR);
  parameter int SIZE_W   = 4;
  parameter int RPN_W    = 30;
  parameter int SEL_W    = 5;

  typedef struct packed {
    logic              valid;
    logic              gs;
    logic [LPID_W-1:0] lpid;
    logic              as_bit;
    logic [PID_W-1:0]  pid;
    logic              ind;
    logic [NTHR-1:0]   thd;
    logic [SIZE_W-1:0] size;
    logic [EPN_W-1:0]  epn;
    logic [RPN_W-1:0]  rpn;
  } tlb_entry_t;

  // search key, ordered guest state, partition, space, process, page
  typedef struct packed {
    logic              gs;
    logic [LPID_W-1:0] lpid;
    logic              as_bit;
    logic [PID_W-1:0]  pid;
    logic [EPN_W-1:0]  epn;
  } srch_key_t;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_search_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  tlb_entry_t               wr_data,
  output tlb_entry_t [ENTRIES-1:0] entries
);
  tlb_entry_t [ENTRIES-1:0] ent_q;
  tlb_entry_t [ENTRIES-1:0] ent_d;

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) ent_d[i] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_q <= '0;
    else if (wr_en) ent_q <= ent_d;
  end

  assign entries = ent_q;
endmodule

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_search_pkg::*;
(
  input  tlb_entry_t       entry,
  input  srch_key_t        key,
  input  logic             key_ind,
  input  logic [TID_W-1:0] thread_id,
  output logic             match
);
  localparam int SH_W = SIZE_W + 1;

  logic [SH_W-1:0]  sh;
  logic [EPN_W-1:0] pmask;
  logic             pg_ok, lpid_ok, pid_ok, ctx_ok;

  always_comb begin
    // size code 0 is treated like the smallest page
    sh      = (entry.size == '0) ? '0 : {entry.size - SIZE_W'(1), 1'b0};
    pmask   = ~((EPN_W'(1) << sh) - EPN_W'(1));
    pg_ok   = ((key.epn & pmask) == (entry.epn & pmask));
    lpid_ok = (entry.lpid == '0) || (entry.lpid == key.lpid);
    pid_ok  = (entry.pid == '0) || (entry.pid == key.pid);
    ctx_ok  = entry.valid && (entry.gs == key.gs) && (entry.as_bit == key.as_bit) &&
              (entry.ind == key_ind) && entry.thd[thread_id];
    match   = ctx_ok && lpid_ok && pid_ok && pg_ok;
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = |match_vec;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_search_unit.sv
module tlb_search_unit
  import tlb_search_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_gs,
  input  logic [LPID_W-1:0] wr_lpid,
  input  logic              wr_as,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic              wr_ind,
  input  logic [NTHR-1:0]   wr_thd,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [EPN_W-1:0]  wr_epn,
  input  logic [RPN_W-1:0]  wr_rpn,
  input  logic              srch_req,
  input  logic              srch_rc,
  input  logic [SEL_W-1:0]  ra_sel,
  input  logic [EA_W-1:0]   ra_val,
  input  logic [EA_W-1:0]   rb_val,
  input  logic              srch_gs,
  input  logic [LPID_W-1:0] srch_lpid,
  input  logic              srch_as,
  input  logic [PID_W-1:0]  srch_pid,
  input  logic              srch_ind,
  input  logic [TID_W-1:0]  thread_id,
  input  logic              cur_gs,
  input  logic              tlb_off,
  input  logic              cfg_hes,
  output logic              done,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [RPN_W-1:0]  hit_rpn,
  output logic              mas_atsel,
  output logic [IDX_W-1:0]  mas_esel,
  output logic              mas_hes,
  output logic [1:0]        mas_wq,
  output logic              mas_v,
  output logic              cr_we,
  output logic [3:0]        cr_flags,
  output logic              exc_priv,
  output logic              exc_ill
);
  // reset synchroniser: asserts at once, releases on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // entry storage
  tlb_entry_t               wr_data;
  tlb_entry_t [ENTRIES-1:0] entries;

  assign wr_data = '{valid: wr_valid, gs: wr_gs, lpid: wr_lpid, as_bit: wr_as, pid: wr_pid,
                     ind: wr_ind, thd: wr_thd, size: wr_size, epn: wr_epn, rpn: wr_rpn};

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .entries(entries)
  );

  // address formation and key
  logic [EA_W-1:0] base, ea;
  srch_key_t       key;

  always_comb begin
    base = (ra_sel == '0) ? '0 : ra_val;
    ea   = base + rb_val;
    key  = '{gs: srch_gs, lpid: srch_lpid, as_bit: srch_as, pid: srch_pid,
             epn: ea[EA_W-1:PG_SHIFT]};
  end

  // parallel compare
  logic [ENTRIES-1:0] match_vec;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_entry_match u_match (
      .entry(entries[g]), .key(key), .key_ind(srch_ind),
      .thread_id(thread_id), .match(match_vec[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] first_idx;
  tlb_first_hit #(.ENTRIES(ENTRIES)) u_first (
    .match_vec(match_vec), .any(any_hit), .idx(first_idx)
  );

  // request qualification
  logic go, priv_d, ill_d;
  always_comb begin
    priv_d = srch_req && cur_gs;
    ill_d  = srch_req && !cur_gs && tlb_off;
    go     = srch_req && !cur_gs && !tlb_off;
  end

  // result next state
  logic             done_d, hit_d, atsel_d, hes_d, v_d, crwe_d;
  logic [IDX_W-1:0] idx_d, esel_d;
  logic [RPN_W-1:0] rpn_d;
  logic [1:0]       wq_d;
  logic [3:0]       cr_d;

  always_comb begin
    done_d  = go;
    crwe_d  = go && srch_rc;
    hit_d   = hit;
    idx_d   = hit_idx;
    rpn_d   = hit_rpn;
    atsel_d = mas_atsel;
    esel_d  = mas_esel;
    hes_d   = mas_hes;
    wq_d    = mas_wq;
    v_d     = mas_v;
    cr_d    = cr_flags;
    if (go) begin
      hit_d = any_hit;
      if (any_hit) begin
        idx_d   = first_idx;
        rpn_d   = entries[first_idx].rpn;
        atsel_d = 1'b0;
        esel_d  = first_idx;
        hes_d   = cfg_hes;
        wq_d    = 2'b01;
        v_d     = 1'b1;
      end else begin
        v_d = 1'b0;
      end
      if (srch_rc) cr_d = {1'b0, 1'b0, any_hit, 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done      <= 1'b0;
      exc_priv  <= 1'b0;
      exc_ill   <= 1'b0;
      cr_we     <= 1'b0;
    end else begin
      done      <= done_d;
      exc_priv  <= priv_d;
      exc_ill   <= ill_d;
      cr_we     <= crwe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit       <= 1'b0;
      hit_idx   <= '0;
      hit_rpn   <= '0;
      mas_atsel <= 1'b0;
      mas_esel  <= '0;
      mas_hes   <= 1'b0;
      mas_wq    <= 2'b00;
      mas_v     <= 1'b0;
      cr_flags  <= 4'b0000;
    end else if (go) begin
      hit       <= hit_d;
      hit_idx   <= idx_d;
      hit_rpn   <= rpn_d;
      mas_atsel <= atsel_d;
      mas_esel  <= esel_d;
      mas_hes   <= hes_d;
      mas_wq    <= wq_d;
      mas_v     <= v_d;
      cr_flags  <= cr_d;
    end
  end

  // R5
  first_hit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (go && any_hit) |-> (match_vec[first_idx] &&
      ((match_vec & ((ENTRIES'(1) << first_idx) - ENTRIES'(1))) == '0)));

  // R6
  hit_fields_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && hit) |-> (mas_v && mas_wq == 2'b01 && !mas_atsel && mas_esel == hit_idx));

  // R7
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !hit) |-> (!mas_v && $stable(hit_idx) && $stable(hit_rpn) && $stable(mas_esel)));

  // R8
  cr_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cr_we |-> (done && cr_flags == {2'b00, hit, 1'b0}));

  // R9
  priv_no_search_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (srch_req && cur_gs) |=> (exc_priv && !done && !exc_ill && $stable(mas_v)));

  // R10
  ill_no_search_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exc_ill |-> (!done && !exc_priv && !cr_we));
endmodule

// File: tb/tlb_search_unit_bench.sv
module tlb_search_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en = 0, wr_valid = 0, wr_gs = 0, wr_as = 0, wr_ind = 0;
  logic [3:0]  wr_idx = 0, wr_thd = 0, wr_size = 0;
  logic [7:0]  wr_lpid = 0;
  logic [13:0] wr_pid = 0;
  logic [51:0] wr_epn = 0;
  logic [29:0] wr_rpn = 0;
  logic        srch_req = 0, srch_rc = 0, srch_gs = 0, srch_as = 0, srch_ind = 0;
  logic        cur_gs = 0, tlb_off = 0, cfg_hes = 0;
  logic [4:0]  ra_sel = 0;
  logic [63:0] ra_val = 0, rb_val = 0;
  logic [7:0]  srch_lpid = 0;
  logic [13:0] srch_pid = 0;
  logic [1:0]  thread_id = 0;
  logic        done, hit, mas_atsel, mas_hes, mas_v, cr_we, exc_priv, exc_ill;
  logic [3:0]  hit_idx, mas_esel, cr_flags;
  logic [29:0] hit_rpn;
  logic [1:0]  mas_wq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_search_unit u_tlb_search_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_gs(wr_gs), .wr_lpid(wr_lpid), .wr_as(wr_as), .wr_pid(wr_pid), .wr_ind(wr_ind),
    .wr_thd(wr_thd), .wr_size(wr_size), .wr_epn(wr_epn), .wr_rpn(wr_rpn),
    .srch_req(srch_req), .srch_rc(srch_rc), .ra_sel(ra_sel), .ra_val(ra_val),
    .rb_val(rb_val), .srch_gs(srch_gs), .srch_lpid(srch_lpid), .srch_as(srch_as),
    .srch_pid(srch_pid), .srch_ind(srch_ind), .thread_id(thread_id), .cur_gs(cur_gs),
    .tlb_off(tlb_off), .cfg_hes(cfg_hes), .done(done), .hit(hit), .hit_idx(hit_idx),
    .hit_rpn(hit_rpn), .mas_atsel(mas_atsel), .mas_esel(mas_esel), .mas_hes(mas_hes),
    .mas_wq(mas_wq), .mas_v(mas_v), .cr_we(cr_we), .cr_flags(cr_flags),
    .exc_priv(exc_priv), .exc_ill(exc_ill)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic v, input logic gs, input logic [7:0] lp,
                      input logic as_b, input logic [13:0] pid, input logic ind,
                      input logic [3:0] thd, input logic [3:0] sz, input logic [51:0] epn,
                      input logic [29:0] rpn);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_valid = v; wr_gs = gs; wr_lpid = lp; wr_as = as_b;
    wr_pid = pid; wr_ind = ind; wr_thd = thd; wr_size = sz; wr_epn = epn; wr_rpn = rpn;
    @(negedge clk);
    wr_en = 0;
  endtask

  // strobe one search; returns at the negedge after the sampling edge
  task automatic search(input logic [4:0] sel, input logic [63:0] ra, input logic [63:0] rb,
                        input logic sgs, input logic [7:0] lp, input logic sas,
                        input logic [13:0] pid, input logic sind, input logic [1:0] thr,
                        input logic cgs, input logic off, input logic rc);
    @(negedge clk);
    ra_sel = sel; ra_val = ra; rb_val = rb; srch_gs = sgs; srch_lpid = lp; srch_as = sas;
    srch_pid = pid; srch_ind = sind; thread_id = thr; cur_gs = cgs; tlb_off = off;
    srch_rc = rc; srch_req = 1;
    @(negedge clk);
    srch_req = 0; cur_gs = 0; tlb_off = 0; srch_rc = 0;
  endtask

  // simple search in the default context (gs0 as0 ind0)
  task automatic s_plain(input logic [63:0] ea, input logic [7:0] lp,
                         input logic [13:0] pid, input logic [1:0] thr);
    search(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, ea, 0, lp, 0, pid, 0, thr, 0, 0, 0);
  endtask

  task automatic t_reset;
    check("R12", "done", done, 0);
    check("R12", "hit", hit, 0);
    check("R12", "mas_v", mas_v, 0);
    check("R12", "exc", {exc_priv, exc_ill, cr_we}, 0);
    s_plain(64'h0, 8'd0, 14'd0, 2'd0);
    check("R12", "empty table miss", {done, hit}, 2'b10);
  endtask

  task automatic t_load;
    load(3, 1, 0, 8'd5, 0, 14'h22, 0, 4'b0001, 4'd1, 52'h12345, 30'h0AAAA);
    load(5, 1, 0, 8'd0, 0, 14'h0, 0, 4'b1111, 4'd0, 52'h00600, 30'h05555);
    load(7, 1, 0, 8'd0, 0, 14'h0, 0, 4'b1111, 4'd3, 52'h50000, 30'h0BBBB);
    load(9, 1, 0, 8'd0, 0, 14'h0, 0, 4'b1111, 4'd1, 52'h50003, 30'h0CCCC);
    load(12, 1, 1, 8'd9, 1, 14'h7, 1, 4'b0100, 4'd1, 52'h00777, 30'h0DDDD);
    load(14, 0, 0, 8'd0, 0, 14'h0, 0, 4'b1111, 4'd1, 52'h00888, 30'h0EEEE);
  endtask

  task automatic t_basic_hit;
    cfg_hes = 1;
    s_plain(64'h0000_0000_1234_5123, 8'd5, 14'h22, 2'd0);
    check("R6", "done", done, 1);
    check("R6", "hit", hit, 1);
    check("R6", "hit_idx", hit_idx, 3);
    check("R6", "hit_rpn", hit_rpn, 30'h0AAAA);
    check("R6", "mas fields", {mas_atsel, mas_esel, mas_hes, mas_wq, mas_v},
          {1'b0, 4'd3, 1'b1, 2'b01, 1'b1});
    check("R8", "no cr_we with rc=0", cr_we, 0);
    @(negedge clk);
    check("R6", "done one cycle", done, 0);
    cfg_hes = 0;
  endtask

  task automatic t_ea;
    search(5'd4, 64'h0000_0000_1200_0000, 64'h0000_0000_0034_5ABC, 0, 8'd5, 0, 14'h22,
           0, 2'd0, 0, 0, 0);
    check("R1", "base+index hit", {hit, hit_idx}, {1'b1, 4'd3});
    check("R6", "hes from cfg", mas_hes, 0);
    search(5'd9, 64'h0000_0000_1234_4FFF, 64'h1, 0, 8'd5, 0, 14'h22, 0, 2'd0, 0, 0, 0);
    check("R1", "carry into page", {hit, hit_idx}, {1'b1, 4'd3});
    search(5'd0, 64'h0000_0000_1234_5000, 64'h0, 0, 8'd5, 0, 14'h22, 0, 2'd0, 0, 0, 0);
    check("R1", "sel 0 ignores ra_val", hit, 0);
  endtask

  task automatic t_size_prio;
    s_plain(64'h0000_0000_5000_3000, 8'h33, 14'h99, 2'd3);
    check("R5", "lowest index wins", {hit, hit_idx, hit_rpn}, {1'b1, 4'd7, 30'h0BBBB});
    check("R3", "wildcard ids", hit, 1);
    s_plain(64'h0000_0000_5000_F000, 8'h01, 14'h01, 2'd1);
    check("R2", "size3 low bits ignored", {hit, hit_idx}, {1'b1, 4'd7});
    s_plain(64'h0000_0000_0060_0000, 8'h01, 14'h01, 2'd1);
    check("R2", "size0 exact", {hit, hit_idx, hit_rpn}, {1'b1, 4'd5, 30'h05555});
    s_plain(64'h0000_0000_0060_1000, 8'h01, 14'h01, 2'd1);
    check("R2", "size0 no wider page", hit, 0);
    s_plain(64'h0000_0000_5001_0000, 8'h01, 14'h01, 2'd1);
    check("R2", "outside large page", hit, 0);
    check("R7", "held idx/rpn", {hit_idx, hit_rpn, mas_esel}, {4'd5, 30'h05555, 4'd5});
  endtask

  task automatic t_ctx;
    s_plain(64'h0000_0000_1234_5000, 8'd5, 14'h22, 2'd1);
    check("R4", "thread bit clear", hit, 0);
    check("R7", "miss clears mas_v", mas_v, 0);
    check("R7", "miss holds wq/atsel", {mas_wq, mas_atsel}, {2'b01, 1'b0});
    s_plain(64'h0000_0000_1234_5000, 8'd6, 14'h22, 2'd0);
    check("R3", "lpid mismatch", hit, 0);
    s_plain(64'h0000_0000_1234_5000, 8'd5, 14'h23, 2'd0);
    check("R3", "pid mismatch", hit, 0);
    search(5'd0, 0, 64'h0077_7000, 1, 8'd9, 1, 14'h7, 1, 2'd2, 0, 0, 0);
    check("R4", "gs/as/ind match", {hit, hit_idx, hit_rpn}, {1'b1, 4'd12, 30'h0DDDD});
    search(5'd0, 0, 64'h0077_7000, 1, 8'd9, 1, 14'h7, 0, 2'd2, 0, 0, 0);
    check("R4", "ind mismatch", hit, 0);
    search(5'd0, 0, 64'h0077_7000, 1, 8'd9, 0, 14'h7, 1, 2'd2, 0, 0, 0);
    check("R4", "as mismatch", hit, 0);
    search(5'd0, 0, 64'h0077_7000, 0, 8'd9, 1, 14'h7, 1, 2'd2, 0, 0, 0);
    check("R4", "gs mismatch", hit, 0);
    s_plain(64'h0000_0000_0088_8000, 8'd0, 14'd0, 2'd0);
    check("R4", "invalid entry", hit, 0);
  endtask

  task automatic t_cr;
    search(5'd0, 0, 64'h1234_5000, 0, 8'd5, 0, 14'h22, 0, 2'd0, 0, 0, 1);
    check("R8", "cr on hit", {cr_we, cr_flags}, {1'b1, 4'b0010});
    @(negedge clk);
    check("R8", "cr_we pulse", cr_we, 0);
    search(5'd0, 0, 64'h1234_5000, 0, 8'd5, 0, 14'h22, 0, 2'd3, 0, 0, 1);
    check("R8", "cr on miss", {cr_we, cr_flags}, {1'b1, 4'b0000});
    s_plain(64'h1234_5000, 8'd5, 14'h22, 2'd0);
    check("R8", "rc=0 holds flags", {cr_we, cr_flags}, {1'b0, 4'b0000});
  endtask

  task automatic t_exc;
    // last search hit entry 3
    search(5'd0, 0, 64'h0060_0000, 0, 8'd1, 0, 14'h1, 0, 2'd0, 1, 0, 1);
    check("R9", "priv pulse", {exc_priv, exc_ill, done, cr_we}, 4'b1000);
    check("R9", "results held", {hit, hit_idx, mas_v}, {1'b1, 4'd3, 1'b1});
    @(negedge clk);
    check("R9", "priv one cycle", exc_priv, 0);
    search(5'd0, 0, 64'h0060_0000, 0, 8'd1, 0, 14'h1, 0, 2'd0, 1, 1, 0);
    check("R9", "priv over ill", {exc_priv, exc_ill}, 2'b10);
    search(5'd0, 0, 64'h0060_0000, 0, 8'd1, 0, 14'h1, 0, 2'd0, 0, 1, 0);
    check("R10", "ill pulse", {exc_priv, exc_ill, done}, 3'b010);
    check("R10", "results held", {hit, hit_idx, hit_rpn}, {1'b1, 4'd3, 30'h0AAAA});
    @(negedge clk);
    check("R10", "ill one cycle", exc_ill, 0);
  endtask

  task automatic t_rewrite;
    load(3, 1, 0, 8'd5, 0, 14'h22, 0, 4'b0001, 4'd1, 52'h12345, 30'h0F00D);
    s_plain(64'h1234_5000, 8'd5, 14'h22, 2'd0);
    check("R11", "new rpn seen", {hit, hit_rpn}, {1'b1, 30'h0F00D});
    load(3, 0, 0, 8'd5, 0, 14'h22, 0, 4'b0001, 4'd1, 52'h12345, 30'h0F00D);
    s_plain(64'h1234_5000, 8'd5, 14'h22, 2'd0);
    check("R11", "invalidated by write", hit, 0);
  endtask

  initial begin
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load();
    t_basic_hit();
    t_ea();
    t_size_prio();
    t_ctx();
    t_cr();
    t_exc();
    t_rewrite();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule